// File: doc/BRIEF.md
# Ring Interconnect Data Arbiter

This block is the central arbiter for a ring-shaped on-chip data network of twelve agents, numbered 0 to 11 around the ring. Four data rings run between the agents: rings 0 and 1 move data clockwise, and rings 2 and 3 move data counter-clockwise. Each agent presents one pending transfer request. The agent's own number is the source, and the request names the destination. Every request arrives over its own point-to-point link. The arbiter picks one requester per cycle in round-robin order. It selects a ring whose path segments are free and which has fewer than three transfers in flight, and it grants the request together with a ring number and a slot tag.

A granted transfer owns its segments on that ring for the whole transaction. When the transfer finishes, the agent's side returns a done pulse carrying the ring and the tag, and the segments become free again. Several transfers may share one ring at the same time if their spans do not overlap. Up to twelve transfers can be in flight across the four rings. The data path, which moves 16 bytes per beat on each ring, is outside this block.

Top module: `ring_data_arbiter`

## Requirements
- R1: Reset is synchronous and active low on `rst_n`. After reset all four rings are empty and no slot is busy, so the first legal request is granted on its preferred ring with tag 0. While no request is valid, `gnt_valid` and `err_valid` stay 0.
- R2: A request is rejected when its destination equals its source or is 12 or higher. The block raises `err_valid` with `err_agent` set to the requester, raises no grant, and leaves the ring state unchanged.
- R3: Hops clockwise = (dst - src) mod 12. Hops counter-clockwise = 12 minus that. The shorter direction is tried first, and a tie at 6 hops tries clockwise first. Within a direction the lower-numbered ring is tried first. If the preferred direction has no usable ring, the two rings of the other direction are tried. `gnt_ring` gives the ring (0,1 clockwise; 2,3 counter-clockwise).
- R4: On clockwise rings, segment i joins agent i to agent i+1. A clockwise path from s to d uses segments s, s+1, ..., d-1. On counter-clockwise rings, segment i joins agent i to agent i-1, and a path uses segments s, s-1, ..., d+1 (all mod 12). A ring is usable only if none of the path's segments are held by a live transfer on that ring.
- R5: A ring holds at most three live transfers. A full ring is unusable even when its segments are free. `gnt_tag` is the lowest free slot (0..2) of the chosen ring.
- R6: At most one grant or error is issued per cycle. Among the valid requests that can be granted now or must be rejected, the first one found searching upward (mod 12) from the agent after the last one served is chosen.
- R7: A grant or error is output in the same cycle as the chosen request and takes effect on the next clock edge. A transfer keeps its segments until `done_valid` names its ring and tag. The segments are freed at that clock edge, so they can be granted again from the following cycle on.
- R8: A valid request that no usable ring can take stays pending and produces no output. It does not prevent other requests from being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 12 | Per-agent request pending; held until that agent sees a grant or error |
| req_dst | input | 12x4 | Per-agent destination agent number |
| done_valid | input | 1 | A live transfer has finished |
| done_ring | input | 2 | Ring of the finished transfer |
| done_tag | input | 2 | Slot tag of the finished transfer |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_agent | output | 4 | Agent granted |
| gnt_ring | output | 2 | Ring assigned |
| gnt_tag | output | 2 | Slot tag assigned on that ring |
| err_valid | output | 1 | A request is rejected this cycle |
| err_agent | output | 4 | Agent rejected |

## Verification
The assertions rely on two things about the inputs. A done pulse only names a ring and tag that currently hold a live transfer. An agent keeps its request and destination steady until its own grant or error appears, and then drops the request on the next edge. The bench's agent model keeps to both rules. It issues at most one done per cycle, picked from transfers its reference model knows to be live, and it clears an agent's pending request only after the agent was served. Any new destination it draws, including illegal ones, is held until that request is resolved.

// File: rtl/ring_arb_pkg.sv
// Shared sizing for the ring data arbiter.
// Assumes an even ring count, split evenly between the two directions.
package ring_arb_pkg;
    localparam int NUM_AGENTS = 12;
    localparam int NUM_RINGS  = 4;
    localparam int RING_SLOTS = 3;
    localparam int AGENT_W    = $clog2(NUM_AGENTS);
    localparam int RING_W     = $clog2(NUM_RINGS);
    localparam int TAG_W      = $clog2(RING_SLOTS);
endpackage

// File: rtl/ring_route_sel.sv
// Route selector for one source agent: builds both path masks, rejects
// illegal destinations and picks the first usable ring in preference order.
// Assumes rings [0, N_RINGS/2) run clockwise and the rest counter-clockwise.
module ring_route_sel #(
    parameter int N_AGENTS = ring_arb_pkg::NUM_AGENTS,
    parameter int N_RINGS  = ring_arb_pkg::NUM_RINGS,
    parameter int SRC      = 0,
    localparam int AW      = $clog2(N_AGENTS),
    localparam int RW      = $clog2(N_RINGS),
    localparam int HALF    = N_RINGS / 2
) (
    input  logic [AW-1:0]                     dst,
    input  logic [N_RINGS-1:0][N_AGENTS-1:0]  occ,
    input  logic [N_RINGS-1:0]                full,
    output logic                              bad,
    output logic                              ok,
    output logic [RW-1:0]                     ring,
    output logic [N_AGENTS-1:0]               path
);
    int                  hops_cw;
    logic                pref_cw;
    logic [N_AGENTS-1:0] cw_m;
    logic [N_AGENTS-1:0] ccw_m;

    // Ring tried at position k of the preference order.
    function automatic int ring_at(input int k, input logic cw_first);
        return cw_first ? k : (k + HALF) % N_RINGS;
    endfunction

    // Hop counts, direction preference and the segment masks of both paths.
    always_comb begin
        bad     = (int'(dst) >= N_AGENTS) || (int'(dst) == SRC);
        hops_cw = (int'(dst) + N_AGENTS - SRC) % N_AGENTS;
        pref_cw = (hops_cw <= N_AGENTS / 2);
        for (int b = 0; b < N_AGENTS; b++) begin
            cw_m[b]  = ((b - SRC + N_AGENTS) % N_AGENTS) < hops_cw;
            ccw_m[b] = ((SRC - b + N_AGENTS) % N_AGENTS) < (N_AGENTS - hops_cw);
        end
    end

    // First ring in preference order that has room and free segments.
    always_comb begin
        ok   = 1'b0;
        ring = '0;
        path = '0;
        for (int k = 0; k < N_RINGS; k++) begin
            if (!ok && !bad && !full[ring_at(k, pref_cw)] &&
                ((occ[ring_at(k, pref_cw)] &
                  ((ring_at(k, pref_cw) < HALF) ? cw_m : ccw_m)) == '0)) begin
                ok   = 1'b1;
                ring = RW'(ring_at(k, pref_cw));
                path = (ring_at(k, pref_cw) < HALF) ? cw_m : ccw_m;
            end
        end
    end
endmodule

// File: rtl/ring_state.sv
// Occupancy of one ring: a fixed number of transaction slots, each holding
// the segment mask of a live transfer. Assumes a release names a live slot
// and an allocation is only requested while a slot is free.
module ring_state #(
    parameter int N_AGENTS = ring_arb_pkg::NUM_AGENTS,
    parameter int SLOTS    = ring_arb_pkg::RING_SLOTS,
    localparam int TW      = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc,
    input  logic [N_AGENTS-1:0] alloc_mask,
    input  logic                rel,
    input  logic [TW-1:0]       rel_tag,
    output logic [N_AGENTS-1:0] occ,
    output logic                full,
    output logic [TW-1:0]       free_tag
);
    logic [SLOTS-1:0]               slot_v;
    logic [SLOTS-1:0][N_AGENTS-1:0] slot_m;
    logic [N_AGENTS-1:0]            rel_mask;

    // Slot bookkeeping: release then fill the lowest free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
            slot_m <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (rel && rel_tag == TW'(s)) slot_v[s] <= 1'b0;
                if (alloc && free_tag == TW'(s)) begin
                    slot_v[s] <= 1'b1;
                    slot_m[s] <= alloc_mask;
                end
            end
        end
    end

    // Combined occupancy, fullness and lowest free slot.
    always_comb begin
        occ      = '0;
        free_tag = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_v[s]) occ = occ | slot_m[s];
            else           free_tag = TW'(s);
        end
        full     = &slot_v;
        rel_mask = slot_m[rel_tag];
    end

    assert_alloc_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> ((alloc_mask & occ) == '0));
    assert_alloc_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);
    assert_rel_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> slot_v[rel_tag]);
    assert_rel_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> ((occ & $past(rel_mask)) == '0));
endmodule

// File: rtl/rr_picker.sv
// Round-robin picker: first eligible index at or above the pointer, wrapping.
// Assumes the pointer is below N.
module rr_picker #(
    parameter int N  = ring_arb_pkg::NUM_AGENTS,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [AW-1:0] ptr,
    output logic          any,
    output logic [AW-1:0] idx
);
    // Rotating search from the pointer.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!any && elig[(int'(ptr) + k) % N]) begin
                any = 1'b1;
                idx = AW'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/ring_data_arbiter.sv
// Central arbiter for the four-ring data network. Each cycle it serves one
// requester in round-robin order with a grant (ring and slot tag) or an error,
// and it frees segments when a done pulse arrives. Assumes requests are held
// until served and done pulses only name live transfers.
module ring_data_arbiter #(
    parameter int N_AGENTS = ring_arb_pkg::NUM_AGENTS,
    parameter int N_RINGS  = ring_arb_pkg::NUM_RINGS,
    parameter int SLOTS    = ring_arb_pkg::RING_SLOTS,
    localparam int AW      = $clog2(N_AGENTS),
    localparam int RW      = $clog2(N_RINGS),
    localparam int TW      = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_AGENTS-1:0]          req_valid,
    input  logic [N_AGENTS-1:0][AW-1:0]  req_dst,
    input  logic                         done_valid,
    input  logic [RW-1:0]                done_ring,
    input  logic [TW-1:0]                done_tag,
    output logic                         gnt_valid,
    output logic [AW-1:0]                gnt_agent,
    output logic [RW-1:0]                gnt_ring,
    output logic [TW-1:0]                gnt_tag,
    output logic                         err_valid,
    output logic [AW-1:0]                err_agent
);
    logic [N_RINGS-1:0][N_AGENTS-1:0]  occ;
    logic [N_RINGS-1:0]                full;
    logic [N_RINGS-1:0][TW-1:0]        free_tag;
    logic [N_AGENTS-1:0]               bad;
    logic [N_AGENTS-1:0]               ok;
    logic [N_AGENTS-1:0][RW-1:0]       ring_sel;
    logic [N_AGENTS-1:0][N_AGENTS-1:0] path_sel;
    logic [N_AGENTS-1:0]               elig;
    logic                              any;
    logic [AW-1:0]                     win;
    logic [AW-1:0]                     ptr;

    // One route selector per source agent.
    for (genvar a = 0; a < N_AGENTS; a++) begin : g_route
        ring_route_sel #(.N_AGENTS(N_AGENTS), .N_RINGS(N_RINGS), .SRC(a)) u_route (
            .dst  (req_dst[a]),
            .occ  (occ),
            .full (full),
            .bad  (bad[a]),
            .ok   (ok[a]),
            .ring (ring_sel[a]),
            .path (path_sel[a])
        );
    end

    assign elig = req_valid & (bad | ok);

    rr_picker #(.N(N_AGENTS)) u_pick (
        .elig (elig),
        .ptr  (ptr),
        .any  (any),
        .idx  (win)
    );

    // Event outputs for the chosen requester.
    always_comb begin
        gnt_valid = any && !bad[win];
        err_valid = any && bad[win];
        gnt_agent = win;
        err_agent = win;
        gnt_ring  = ring_sel[win];
        gnt_tag   = free_tag[ring_sel[win]];
    end

    // One occupancy tracker per ring.
    for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
        ring_state #(.N_AGENTS(N_AGENTS), .SLOTS(SLOTS)) u_state (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (gnt_valid && gnt_ring == RW'(r)),
            .alloc_mask (path_sel[win]),
            .rel        (done_valid && done_ring == RW'(r)),
            .rel_tag    (done_tag),
            .occ        (occ[r]),
            .full       (full[r]),
            .free_tag   (free_tag[r])
        );
    end

    // Round-robin pointer moves past the agent served.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (any) ptr <= (win == AW'(N_AGENTS - 1)) ? '0 : win + AW'(1);
    end

    assert_served_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid || err_valid) |-> req_valid[gnt_agent]);
    assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (int'(req_dst[err_agent]) >= N_AGENTS ||
                       req_dst[err_agent] == err_agent));
endmodule

// File: tb/tb_ring_data_arbiter.sv
`timescale 1ns/1ps
module tb_ring_data_arbiter;
    localparam int NA = 12;
    localparam int NR = 4;
    localparam int NS = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NA-1:0]     req_valid;
    logic [NA-1:0][3:0] req_dst;
    logic              done_valid;
    logic [1:0]        done_ring;
    logic [1:0]        done_tag;
    logic              gnt_valid, err_valid;
    logic [3:0]        gnt_agent, err_agent;
    logic [1:0]        gnt_ring, gnt_tag;

    always #2 clk = ~clk;

    ring_data_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .done_valid(done_valid), .done_ring(done_ring), .done_tag(done_tag),
        .gnt_valid(gnt_valid), .gnt_agent(gnt_agent), .gnt_ring(gnt_ring),
        .gnt_tag(gnt_tag), .err_valid(err_valid), .err_agent(err_agent)
    );

    int  checks = 0, failures = 0;
    int  pend [NA];
    int  pdst [NA];
    bit  mv   [NR][NS];
    int  mmask[NR][NS];
    int  life [NR][NS];
    int  ptr = 0;
    bit  auto_mode = 0;
    bit  finished = 0;
    int  man_ring = -1, man_tag = 0;
    int  d_ring, d_tag;
    bit  d_on;
    bit  o_g, o_e;
    int  o_a, o_r, o_t;

    task automatic check(input bit good, input string what, input int act, input int exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Segments walked from s to d in one direction.
    function automatic int walk(input int s, input int d, input bit cw);
        int m = 0;
        int cur = s;
        while (cur != d) begin
            m = m | (1 << cur);
            cur = cw ? (cur + 1) % NA : (cur + NA - 1) % NA;
        end
        return m;
    endfunction

    function automatic int ring_occ(input int r);
        int m = 0;
        for (int s = 0; s < NS; s++) if (mv[r][s]) m = m | mmask[r][s];
        return m;
    endfunction

    task automatic drive();
        if (auto_mode) begin
            for (int i = 0; i < NA; i++)
                if (!pend[i] && $urandom_range(0, 3) == 0) begin
                    pend[i] = 1;
                    pdst[i] = $urandom_range(0, 13);
                end
        end
        d_on = 0; d_ring = 0; d_tag = 0;
        if (man_ring >= 0) begin
            d_on = 1; d_ring = man_ring; d_tag = man_tag; man_ring = -1;
        end else if (auto_mode) begin
            for (int r = 0; r < NR; r++)
                for (int s = 0; s < NS; s++)
                    if (!d_on && mv[r][s] && life[r][s] <= 0) begin
                        d_on = 1; d_ring = r; d_tag = s;
                    end
        end
        done_valid = d_on;
        done_ring  = 2'(d_ring);
        done_tag   = 2'(d_tag);
        for (int i = 0; i < NA; i++) begin
            req_valid[i] = pend[i] != 0;
            req_dst[i]   = 4'(pdst[i]);
        end
    endtask

    task automatic evaluate();
        bit e_g = 0, e_e = 0;
        int e_a = 0, e_r = 0, e_t = 0, e_m = 0;
        for (int k = 0; k < NA; k++) begin
            int j = (ptr + k) % NA;
            if (!e_g && !e_e && pend[j]) begin
                int d = pdst[j];
                if (d == j || d >= NA) begin
                    e_e = 1; e_a = j;
                end else begin
                    int cw = (d - j + NA) % NA;
                    for (int q = 0; q < NR; q++) begin
                        int r = (cw <= NA - cw) ? q : (q + 2) % NR;
                        int pm = walk(j, d, r < 2);
                        int cnt = 0;
                        int ft = -1;
                        for (int s = 0; s < NS; s++) begin
                            if (mv[r][s]) cnt++;
                            else if (ft < 0) ft = s;
                        end
                        if (!e_g && cnt < NS && (ring_occ(r) & pm) == 0) begin
                            e_g = 1; e_a = j; e_r = r; e_t = ft; e_m = pm;
                        end
                    end
                end
            end
        end
        o_g = gnt_valid; o_e = err_valid;
        o_a = gnt_valid ? int'(gnt_agent) : int'(err_agent);
        o_r = int'(gnt_ring); o_t = int'(gnt_tag);
        check(gnt_valid == e_g, "R6/R8 gnt_valid", gnt_valid, e_g);
        check(err_valid == e_e, "R2 err_valid", err_valid, e_e);
        if (e_g && gnt_valid) begin
            check(int'(gnt_agent) == e_a, "R6 gnt_agent", gnt_agent, e_a);
            check(int'(gnt_ring) == e_r, "R3/R4 gnt_ring", gnt_ring, e_r);
            check(int'(gnt_tag) == e_t, "R5 gnt_tag", gnt_tag, e_t);
        end
        if (e_e && err_valid)
            check(int'(err_agent) == e_a, "R2 err_agent", err_agent, e_a);
        // Model state update, matching what the next edge does.
        if (d_on) mv[d_ring][d_tag] = 0;
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < NS; s++) life[r][s]--;
        if (e_g) begin
            mv[e_r][e_t] = 1; mmask[e_r][e_t] = e_m;
            life[e_r][e_t] = auto_mode ? $urandom_range(1, 12) : 1000000;
        end
        if (e_g || e_e) begin
            pend[e_a] = 0;
            ptr = (e_a + 1) % NA;
        end
    endtask

    task automatic cycle();
        @(posedge clk); #1;
        drive();
        @(negedge clk);
        evaluate();
    endtask

    task automatic post(input int a, input int d);
        pend[a] = 1; pdst[a] = d;
    endtask

    initial begin
        for (int i = 0; i < NA; i++) begin pend[i] = 0; pdst[i] = 0; end
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < NS; s++) begin mv[r][s] = 0; mmask[r][s] = 0; life[r][s] = 0; end
        rst_n = 1'b0; req_valid = '0; req_dst = '0;
        done_valid = 1'b0; done_ring = '0; done_tag = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        cycle();
        check(!o_g && !o_e, "R1 idle after reset", o_g | o_e, 0);
        post(3, 3); cycle();
        check(o_e && o_a == 3, "R2 self destination error", o_a, 3);
        post(0, 6); cycle();
        check(o_g && o_r == 0 && o_t == 0, "R1 R3 tie goes clockwise ring 0 tag 0", o_r * 4 + o_t, 0);
        post(6, 0); cycle();
        check(o_g && o_r == 0 && o_t == 1, "R4 disjoint span shares ring 0 tag 1", o_r * 4 + o_t, 1);
        post(1, 3); cycle();
        check(o_g && o_r == 1 && o_t == 0, "R4 overlap moves to ring 1", o_r * 4 + o_t, 4);
        post(2, 4); cycle();
        check(o_g && o_r == 2, "R3 fallback to counter-clockwise ring 2", o_r, 2);
        post(0, 6); cycle();
        check(o_g && o_r == 3, "R3 fallback to ring 3", o_r, 3);
        post(0, 6); cycle();
        check(!o_g && !o_e, "R8 blocked request stays pending", o_g, 0);
        man_ring = 1; man_tag = 0; cycle();
        check(!o_g, "R7 release not visible in its own cycle", o_g, 0);
        cycle();
        check(o_g && o_r == 1 && o_t == 0, "R7 freed segments granted next cycle", o_r * 4 + o_t, 4);
        post(8, 9); cycle();
        check(o_g && o_r == 1 && o_t == 1, "R5 second slot on ring 1", o_r * 4 + o_t, 5);
        post(10, 11); cycle();
        check(o_g && o_r == 1 && o_t == 2, "R5 third slot on ring 1", o_r * 4 + o_t, 6);
        post(9, 10); cycle();
        check(!o_g, "R5 full ring refuses free span", o_g, 0);
        man_ring = 1; man_tag = 1; cycle();
        cycle();
        check(o_g && o_r == 1 && o_t == 1, "R5 R7 slot reuse after release", o_r * 4 + o_t, 5);

        auto_mode = 1;
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < NS; s++) life[r][s] = 3 + r + s;
        repeat (4000) cycle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule